// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature sensor front end converts and for how long. It counts a 1.25 ms timebase tick and raises a busy level for the length of each conversion, ending it with a one-cycle done strobe. While the block is enabled, conversions start at a fixed period chosen from seven rates. While it is shut down, a one-shot request starts a single conversion. The conversion length follows the selected resolution and doubles for each extra bit. The block also reports the temperature weight of one result LSB for that resolution.

Configuration comes in through a single write strobe. The strobe carries the shutdown flag, the rate code and the resolution code. A write that keeps an already running block enabled does not load the rate code. It sets the period to one second instead. The sensing itself and the result datapath sit outside this block.

Top module: `conv_sched`

## Requirements
- R1: After reset the block is enabled, conv_busy and conv_done are 0, the period is 1 s and the resolution is 12 bits (lsb_weight = 1).
- R2: While enabled, a conversion starts on the first tick after reset or after a configuration write. After that, a new conversion starts every P ticks. P is BASE_TICKS (default 100) times 512, 256, 128, 32, 8, 2 or 1 for rate codes 0 to 6, which gives 64 s, 32 s, 16 s, 4 s, 1 s, 250 ms and 125 ms.
- R3: Rate code 7 gives the same period as code 4 (1 s).
- R4: conv_busy stays high for exactly D ticks. D is CONV_BASE (default 7) times 1, 2, 4 or 16 for resolution codes 0, 1, 2 and 3 (8, 9, 10 and 12 bits). conv_done is a one-cycle pulse in the first cycle that conv_busy is low again.
- R5: lsb_weight gives the LSB weight in units of 1/16 °C: 16, 8, 4 and 1 for resolution codes 0 to 3.
- R6: A period start that arrives while a conversion is busy is dropped. The next start waits for the following period boundary.
- R7: A configuration write with shutdown at 0, made while the block is already enabled, sets the period to 1 s whatever the rate code is.
- R8: A write that enters shutdown lets the conversion in progress finish with its done strobe. After that, no further periodic conversion starts.
- R9: While shut down and idle, a one-shot request runs exactly one conversion. A request made while enabled or while busy is ignored.
- R10: A conversion keeps the length it had when it started, even if the resolution is changed while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle every 1.25 ms |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_shdn | input | 1 | Shutdown flag carried by the write |
| cfg_rate | input | 3 | Rate code carried by the write |
| cfg_res | input | 2 | Resolution code carried by the write |
| oneshot_req | input | 1 | One-shot conversion request |
| conv_busy | output | 1 | A conversion is running |
| conv_done | output | 1 | One-cycle pulse when a conversion ends |
| lsb_weight | output | 5 | LSB weight of the current resolution, in 1/16 °C |

## Verification
Continuous runs use the 125 ms, 250 ms, 1 s, 4 s and code-7 periods, paired with different resolutions. Each conversion's start tick and its busy length are compared, which separates a period error from a duration error. A run where a 12-bit conversion is longer than the 125 ms period shows that overlapping boundaries are dropped rather than queued. A write that keeps the block enabled shows the forced 1 s period. One-shot runs use both a dense and a sparse tick pattern. Requests made while enabled and while busy show that those requests are ignored. A shutdown written during a conversion, together with a resolution change, shows that the conversion finishes at its original length.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  localparam logic [2:0] RATE_ONE_SEC = 3'd4;
  localparam logic [1:0] RES_FINEST   = 2'd3;

  // Period in ticks: base is the tick count of the shortest period.
  function automatic int unsigned period_ticks(input logic [2:0] code,
                                               input int unsigned base);
    case (code)
      3'd0:    return base * 512;
      3'd1:    return base * 256;
      3'd2:    return base * 128;
      3'd3:    return base * 32;
      3'd5:    return base * 2;
      3'd6:    return base;
      default: return base * 8;
    endcase
  endfunction

  // Conversion length in ticks, doubling per extra bit of resolution.
  function automatic int unsigned conv_ticks(input logic [1:0] res,
                                             input int unsigned base);
    case (res)
      2'd0:    return base;
      2'd1:    return base * 2;
      2'd2:    return base * 4;
      default: return base * 16;
    endcase
  endfunction

  // LSB weight in sixteenths of a degree.
  function automatic logic [4:0] lsb_q4(input logic [1:0] res);
    case (res)
      2'd0:    return 5'd16;
      2'd1:    return 5'd8;
      2'd2:    return 5'd4;
      default: return 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
  import conv_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_shdn,
  input  logic [2:0] cfg_rate,
  input  logic [1:0] cfg_res,
  output logic       shut_dn,
  output logic [2:0] rate_cur,
  output logic [1:0] res_cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_dn  <= 1'b0;
      rate_cur <= RATE_ONE_SEC;
      res_cur  <= RES_FINEST;
    end else if (cfg_wr) begin
      shut_dn <= cfg_shdn;
      res_cur <= cfg_res;
      // Staying enabled across a write forces the one-second period.
      if (!shut_dn && !cfg_shdn) rate_cur <= RATE_ONE_SEC;
      else                       rate_cur <= cfg_rate;
    end
  end

endmodule

// File: rtl/sched_period_timer.sv
module sched_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] period,
  output logic          boundary
);

  logic [PW-1:0] pcnt;

  assign boundary = tick && run && !restart && (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart || !run) begin
      pcnt <= '0;
    end else if (tick) begin
      if (pcnt >= period - PW'(1)) pcnt <= '0;
      else                         pcnt <= pcnt + PW'(1);
    end
  end

endmodule

// File: rtl/sched_conv_timer.sv
module sched_conv_timer #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_req,
  input  logic [LW-1:0] len_in,
  output logic          busy,
  output logic          done,
  output logic          start_acc,
  output logic [LW-1:0] len_cur
);

  logic [LW-1:0] ccnt;

  assign start_acc = start_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ccnt    <= '0;
      len_cur <= '0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        busy    <= 1'b1;
        ccnt    <= '0;
        len_cur <= len_in;
      end else if (busy && tick) begin
        if (ccnt == len_cur - LW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ccnt <= ccnt + LW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int BASE_TICKS = 100,
  parameter int CONV_BASE  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_wr,
  input  logic       cfg_shdn,
  input  logic [2:0] cfg_rate,
  input  logic [1:0] cfg_res,
  input  logic       oneshot_req,
  output logic       conv_busy,
  output logic       conv_done,
  output logic [4:0] lsb_weight
);

  localparam int PW = $clog2(BASE_TICKS * 512 + 1);
  localparam int LW = $clog2(CONV_BASE * 16 + 1);

  logic          shut_dn;
  logic [2:0]    rate_cur;
  logic [1:0]    res_cur;
  logic [PW-1:0] period_len;
  logic [LW-1:0] conv_len_sel;
  logic [LW-1:0] conv_len;
  logic          period_boundary;
  logic          oneshot_go;
  logic          conv_start_req;
  logic          conv_start_acc;

  sched_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_shdn (cfg_shdn),
    .cfg_rate (cfg_rate),
    .cfg_res  (cfg_res),
    .shut_dn  (shut_dn),
    .rate_cur (rate_cur),
    .res_cur  (res_cur)
  );

  assign period_len   = PW'(period_ticks(rate_cur, BASE_TICKS));
  assign conv_len_sel = LW'(conv_ticks(res_cur, CONV_BASE));
  assign lsb_weight   = lsb_q4(res_cur);

  sched_period_timer #(.PW(PW)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (!shut_dn),
    .restart  (cfg_wr),
    .period   (period_len),
    .boundary (period_boundary)
  );

  assign oneshot_go     = oneshot_req && shut_dn && !cfg_wr;
  assign conv_start_req = period_boundary || oneshot_go;

  sched_conv_timer #(.LW(LW)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_req (conv_start_req),
    .len_in    (conv_len_sel),
    .busy      (conv_busy),
    .done      (conv_done),
    .start_acc (conv_start_acc),
    .len_cur   (conv_len)
  );

endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          shut_dn,
  input logic          period_boundary,
  input logic          oneshot_go,
  input logic          conv_start_acc,
  input logic          conv_busy,
  input logic          conv_done,
  input logic [LW-1:0] conv_len
);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R4
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (!conv_busy && $past(conv_busy) && $past(tick)));

  // R2
  boundary_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_boundary |-> tick);

  // R8
  no_periodic_in_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_dn |-> !period_boundary);

  // R9
  oneshot_only_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_go |-> shut_dn);

  // R6
  busy_rise_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_acc |=> conv_busy);

  // R10
  len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && $past(conv_busy)) |-> $stable(conv_len));

endmodule

bind conv_sched conv_sched_chk #(.LW(LW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tick            (tick),
  .shut_dn         (shut_dn),
  .period_boundary (period_boundary),
  .oneshot_go      (oneshot_go),
  .conv_start_acc  (conv_start_acc),
  .conv_busy       (conv_busy),
  .conv_done       (conv_done),
  .conv_len        (conv_len)
);

// File: tb/tb_conv_sched.sv
`timescale 1ns/1ps
module tb_conv_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_shdn = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic [1:0] cfg_res = 2'd0;
  logic       oneshot_req = 1'b0;
  logic       conv_busy;
  logic       conv_done;
  logic [4:0] lsb_weight;

  conv_sched dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_shdn(cfg_shdn), .cfg_rate(cfg_rate), .cfg_res(cfg_res),
    .oneshot_req(oneshot_req), .conv_busy(conv_busy),
    .conv_done(conv_done), .lsb_weight(lsb_weight)
  );

  always #2.5 clk = ~clk;

  typedef struct { int unsigned st; int unsigned ln; } conv_item_t;
  conv_item_t  expq[$];
  int unsigned tidx = 0;
  int unsigned tick_gap = 0;
  int unsigned tick_ph = 0;
  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cur_start = 0;
  logic        busy_q = 1'b0;

  // Own restatement of the timing tables, from milliseconds.
  function automatic int unsigned exp_period(input int code);
    int unsigned ms;
    case (code)
      0: ms = 64000; 1: ms = 32000; 2: ms = 16000; 3: ms = 4000;
      5: ms = 250;   6: ms = 125;   default: ms = 1000;
    endcase
    return (ms * 4) / 5;
  endfunction

  function automatic int unsigned res_bits(input int res);
    return (res == 3) ? 12 : 8 + res;
  endfunction

  function automatic int unsigned exp_len(input int res);
    return 7 << (res_bits(res) - 8);
  endfunction

  function automatic int unsigned exp_lsb(input int res);
    return 16 >> (res_bits(res) - 8);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (tick) tidx <= tidx + 1;

  always @(negedge clk) begin
    if (tick_gap == 0) tick <= 1'b0;
    else begin
      tick_ph = tick_ph + 1;
      tick <= ((tick_ph % tick_gap) == 0);
    end
  end

  // Monitor: records start tick on busy rise, compares on done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_busy && !busy_q) cur_start = tidx;
      if (conv_done) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R6/R8/R9 unexpected conversion start", cur_start, -1);
        end else begin
          conv_item_t e;
          e = expq.pop_front();
          chk(cur_start == e.st, "R2/R9 start tick", cur_start, e.st);
          chk(tidx - cur_start == e.ln, "R4/R10 busy length", tidx - cur_start, e.ln);
        end
      end
      busy_q = conv_busy;
    end
  end

  task automatic cfg_write(input bit sd, input int rate, input int res);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_shdn = sd; cfg_rate = 3'(rate); cfg_res = 2'(res);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_tidx(input int unsigned n);
    while (tidx < n) @(negedge clk);
  endtask

  task automatic pulse_oneshot();
    @(negedge clk); oneshot_req = 1'b1;
    @(negedge clk); oneshot_req = 1'b0;
  endtask

  // Driver: enable with a rate and resolution, push expected conversions.
  task automatic cont_phase(input int rate, input int res, input int k,
                            input int unsigned step, input string req);
    int unsigned s0;
    conv_item_t  it;
    cfg_write(1'b0, rate, res);
    s0 = tidx + 1;
    for (int i = 0; i < k; i++) begin
      it.st = s0 + i * step; it.ln = exp_len(res);
      expq.push_back(it);
    end
    chk(lsb_weight == exp_lsb(res), "R5 lsb weight", lsb_weight, exp_lsb(res));
    // R9: a request while enabled must not start anything.
    wait_tidx(s0 + exp_len(res) + 3);
    pulse_oneshot();
    wait_tidx(s0 + (k - 1) * step + exp_len(res) + 2);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic oneshot_phase(input int res, input int unsigned gap);
    conv_item_t it;
    cfg_write(1'b1, 4, res);
    chk(lsb_weight == exp_lsb(res), "R5 lsb weight", lsb_weight, exp_lsb(res));
    tick_gap = gap;
    @(negedge clk); oneshot_req = 1'b1;
    @(negedge clk); oneshot_req = 1'b0;
    it.st = tidx; it.ln = exp_len(res);
    expq.push_back(it);
    // Second request while busy: ignored (R9).
    pulse_oneshot();
    wait_tidx(it.st + it.ln + 30);
    chk(expq.size() == 0, "R9 single one-shot", expq.size(), 0);
    chk(conv_busy == 1'b0, "R9 idle after one-shot", conv_busy, 0);
    tick_gap = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", tidx, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    conv_item_t it;
    repeat (4) @(negedge clk);
    chk(conv_busy == 1'b0, "R1 busy at reset", conv_busy, 0);
    chk(conv_done == 1'b0, "R1 done at reset", conv_done, 0);
    chk(lsb_weight == 5'd1, "R1 lsb at reset", lsb_weight, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2: defaults run 12-bit conversions every second from the first tick.
    it.st = 1;   it.ln = 112; expq.push_back(it);
    it.st = 801; it.ln = 112; expq.push_back(it);
    tick_gap = 1;
    wait_tidx(803);
    // R8/R10: shut down mid-conversion and change resolution.
    cfg_write(1'b1, 4, 0);
    chk(lsb_weight == 5'd16, "R5 lsb after res change", lsb_weight, 16);
    wait_tidx(1000);
    chk(expq.size() == 0, "R8 in-flight conversion finished", expq.size(), 0);
    wait_tidx(2000);
    chk(conv_busy == 1'b0, "R8 no periodic start in shutdown", conv_busy, 0);

    oneshot_phase(0, 1);
    oneshot_phase(1, 3);
    oneshot_phase(2, 1);

    cont_phase(6, 0, 3, exp_period(6), "R2 period 125 ms");
    cont_phase(2, 0, 2, 800, "R7 forced 1 s on enable while enabled");
    cfg_write(1'b1, 4, 0);
    cont_phase(7, 1, 2, exp_period(4), "R3 code 7 as 1 s");
    cfg_write(1'b1, 4, 0);
    cont_phase(5, 2, 3, exp_period(5), "R2 period 250 ms");
    cfg_write(1'b1, 4, 0);
    cont_phase(3, 0, 2, exp_period(3), "R2 period 4 s");
    cfg_write(1'b1, 4, 0);
    cont_phase(6, 3, 3, 2 * exp_period(6), "R6 overlapping boundary dropped");
    cfg_write(1'b1, 4, 0);
    wait_tidx(tidx + 300);
    chk(expq.size() == 0, "R8 quiet after shutdown", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule